// File: doc/BRIEF.md
# Write-Back Direct-Mapped Level-One Data Cache

This block is a single-way level-one data cache with a write-back policy. It holds 16 KB in 512 lines of 32 bytes. A core issues loads and stores through a valid/ready port that carries an address, eight byte enables and a 64-bit store word. A load that hits returns its word in the same cycle in which the request is accepted. Every stored byte carries one even-parity check bit. The check on a returned word finishes one cycle later, on a separate late-error output, so the hit path does not wait for it.

A miss drops ready and holds it low until the line is present. If the victim line is dirty, its four 64-bit beats go out to memory first, with their check bits. The four-beat refill comes after. The held request then retires from the refilled line. A store miss allocates the line in this way and then merges its bytes. Store hits write only the cache and mark the line dirty. The memory side moves one beat per handshake: the cache holds a beat until memory acknowledges it.

Top module: `wb_dcache`

## Requirements
- R1: Address bits [4:0] select the byte in a line, bits [13:5] select one of 512 lines, and bits [31:14] form the tag. Two addresses that are 16 KB apart share a line and evict each other, and this includes the last line (index 511).
- R2: A load (req_we_i=0) that hits raises rsp_valid_o and presents the stored 64-bit word on rsp_rdata_o in the same cycle as the accepting handshake, with no memory traffic.
- R3: In the cycle after a load-hit response, rsp_err_o is high exactly when, for some byte b with req_be_i[b]=1, data bits [8b+7:8b] together with check bit b hold an odd number of ones. rsp_err_o is low at every other time.
- R4: A store hit writes only the enabled bytes (req_be_i[b] selects bits [8b+7:8b]), regenerates their check bits, marks the line dirty and creates no memory traffic.
- R5: A miss on an invalid or clean line issues exactly four read beats with mem_rd_o, at line base + 0, 8, 16 and 24 in that order, and no write beats.
- R6: A miss on a dirty line first issues four write beats with mem_wr_o, carrying the victim's address (victim tag and index), data and check bits in ascending order. Only after them come the four read beats of the new line.
- R7: A store miss refills the line, merges the enabled store bytes into it and leaves it dirty, so a later eviction writes it back.
- R8: From the detection of a miss until the refill completes, req_ready_o is low and no request is accepted. The held request then completes from the refilled line.
- R9: Reset clears all valid and dirty bits. After reset, req_ready_o is high with no request pending, no memory beat is issued, every earlier line misses, and an eviction writes nothing back.
- R10: A memory beat keeps mem_rd_o, mem_wr_o, mem_addr_o and the write data stable until mem_ack_i is sampled high. Each acknowledged beat is transferred once, whatever the acknowledgement delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Core request valid, held until accepted |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address of the 64-bit word |
| req_be_i | input | 8 | Byte enables |
| req_wdata_i | input | 64 | Store data |
| rsp_valid_o | output | 1 | Load hit data valid this cycle |
| rsp_rdata_o | output | 64 | Load data |
| rsp_err_o | output | 1 | Late parity error for the previous cycle's load |
| mem_rd_o | output | 1 | Refill beat request |
| mem_wr_o | output | 1 | Writeback beat request |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_wdata_o | output | 64 | Writeback beat data |
| mem_wpar_o | output | 8 | Writeback beat check bits |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_rdata_i | input | 64 | Refill beat data |
| mem_rpar_i | input | 8 | Refill beat check bits |

## Verification
The checker watches the memory handshake on every cycle: read and write beats are never both requested, and an unacknowledged beat never changes. It also checks that ready stays low while beats are in flight, that a writeback is always followed directly by a refill, that a response only comes with an accepted load, and that the late error only follows a response. Only the bench scenarios can show that the data is right. These cover merged store bytes, written-back victim contents, beat address order, aliasing at the top index, parity faults injected into refilled words and cleared by later stores, and the loss of cached state at reset.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL
  } state_e;
endpackage

// File: rtl/wb_dcache_tags.sv
module wb_dcache_tags #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned TAG_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o,
  input  logic             mark_dirty_i,
  input  logic             fill_done_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  always_ff @(posedge clk_i) begin
    if (fill_done_i) tag_q[idx_i] <= fill_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
endmodule

// File: rtl/wb_dcache_data.sv
module wb_dcache_data import wb_dcache_pkg::*; #(
  parameter int unsigned WADDR_W = 11
) (
  input  logic                  clk_i,
  input  logic [WADDR_W-1:0]    raddr_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic [WORD_BYTES-1:0] rpar_o,
  input  logic                  we_i,
  input  logic [WADDR_W-1:0]    waddr_i,
  input  logic [WORD_BYTES-1:0] wbe_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic [WORD_BYTES-1:0] wpar_i
);
  localparam int unsigned WORDS = 1 << WADDR_W;

  logic [WORD_W-1:0]     data_q [WORDS];
  logic [WORD_BYTES-1:0] par_q  [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (wbe_i[b]) begin
          data_q[waddr_i][8*b +: 8] <= wdata_i[8*b +: 8];
          par_q[waddr_i][b]         <= wpar_i[b];
        end
      end
    end
  end

  // asynchronous read: hit data leaves in the access cycle
  assign rdata_o = data_q[raddr_i];
  assign rpar_o  = par_q[raddr_i];
endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl import wb_dcache_pkg::*; #(
  parameter int unsigned LINE_W = 27,
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              hit_i,
  input  logic              victim_dirty_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic              mem_ack_i,
  output state_e            state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [LINE_W-1:0] line_o,
  output logic              last_o
);
  state_e            state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [LINE_W-1:0] line_q;

  assign last_o = beat_q == {BEAT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      line_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i && !hit_i) begin
          line_q  <= req_line_i;
          beat_q  <= '0;
          state_q <= victim_dirty_i ? ST_EVICT : ST_FILL;
        end
        ST_EVICT: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_o) state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign line_o  = line_q;
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache import wb_dcache_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CAP_BYTES  = 16384,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [WORD_BYTES-1:0] req_be_i,
  input  logic [WORD_W-1:0]     req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [WORD_W-1:0]     rsp_rdata_o,
  output logic                  rsp_err_o,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [WORD_W-1:0]     mem_wdata_o,
  output logic [WORD_BYTES-1:0] mem_wpar_o,
  input  logic                  mem_ack_i,
  input  logic [WORD_W-1:0]     mem_rdata_i,
  input  logic [WORD_BYTES-1:0] mem_rpar_i
);
  localparam int unsigned BEATS   = LINE_BYTES / WORD_BYTES;
  localparam int unsigned LINES   = CAP_BYTES / LINE_BYTES;
  localparam int unsigned BSEL_W  = $clog2(WORD_BYTES);
  localparam int unsigned BEAT_W  = $clog2(BEATS);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned IDX_W   = $clog2(LINES);
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned LINE_W  = ADDR_W - OFF_W;
  localparam int unsigned WADDR_W = IDX_W + BEAT_W;

  state_e                state;
  logic [BEAT_W-1:0]     beat;
  logic [LINE_W-1:0]     line_q;
  logic                  last_beat;
  logic [IDX_W-1:0]      req_idx, idx;
  logic [TAG_W-1:0]      req_tag, tag_rd;
  logic [BEAT_W-1:0]     req_wsel;
  logic                  valid_rd, dirty_rd, hit, idle;
  logic                  store_hit, fill_we, fill_done;
  logic [WADDR_W-1:0]    raddr, waddr;
  logic [WORD_W-1:0]     rd_data, wdata;
  logic [WORD_BYTES-1:0] rd_par, wpar, wbe, st_par, rd_bad;
  logic                  err_q;
  logic                  unused_low;

  assign req_idx    = req_addr_i[OFF_W +: IDX_W];
  assign req_tag    = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_wsel   = req_addr_i[BSEL_W +: BEAT_W];
  assign unused_low = ^req_addr_i[BSEL_W-1:0];

  assign idle = state == ST_IDLE;
  assign idx  = idle ? req_idx : line_q[IDX_W-1:0];
  assign hit  = valid_rd && (tag_rd == req_tag);

  wb_dcache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (idx),
    .tag_o        (tag_rd),
    .valid_o      (valid_rd),
    .dirty_o      (dirty_rd),
    .mark_dirty_i (store_hit),
    .fill_done_i  (fill_done),
    .fill_tag_i   (line_q[LINE_W-1 -: TAG_W])
  );

  wb_dcache_ctrl #(.LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .hit_i          (hit),
    .victim_dirty_i (valid_rd && dirty_rd),
    .req_line_i     (req_addr_i[ADDR_W-1:OFF_W]),
    .mem_ack_i      (mem_ack_i),
    .state_o        (state),
    .beat_o         (beat),
    .line_o         (line_q),
    .last_o         (last_beat)
  );

  generate
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_par
      assign st_par[b] = ^req_wdata_i[8*b +: 8];
      assign rd_bad[b] = ^{rd_data[8*b +: 8], rd_par[b]};
    end
  endgenerate

  assign store_hit = idle && req_valid_i && hit && req_we_i;
  assign fill_we   = (state == ST_FILL) && mem_ack_i;
  assign fill_done = fill_we && last_beat;

  assign raddr = idle ? {req_idx, req_wsel} : {idx, beat};
  assign waddr = store_hit ? {req_idx, req_wsel} : {idx, beat};
  assign wbe   = store_hit ? req_be_i : {WORD_BYTES{1'b1}};
  assign wdata = store_hit ? req_wdata_i : mem_rdata_i;
  assign wpar  = store_hit ? st_par : mem_rpar_i;

  wb_dcache_data #(.WADDR_W(WADDR_W)) u_data (
    .clk_i   (clk_i),
    .raddr_i (raddr),
    .rdata_o (rd_data),
    .rpar_o  (rd_par),
    .we_i    (store_hit || fill_we),
    .waddr_i (waddr),
    .wbe_i   (wbe),
    .wdata_i (wdata),
    .wpar_i  (wpar)
  );

  assign req_ready_o = idle && (!req_valid_i || hit);
  assign rsp_valid_o = idle && req_valid_i && hit && !req_we_i;
  assign rsp_rdata_o = rd_data;

  // parity verdict lands one cycle after the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= rsp_valid_o && |(rd_bad & req_be_i);
  end
  assign rsp_err_o = err_q;

  assign mem_rd_o    = state == ST_FILL;
  assign mem_wr_o    = state == ST_EVICT;
  assign mem_addr_o  = mem_wr_o ? {tag_rd, idx, beat, {BSEL_W{1'b0}}}
                                : {line_q, beat, {BSEL_W{1'b0}}};
  assign mem_wdata_o = rd_data;
  assign mem_wpar_o  = rd_par;
endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       mem_wdata_o,
  input logic              mem_ack_i
);
  p_rd_wr_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_beat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ack_i |=>
      $stable(mem_addr_o) && $stable(mem_rd_o) && $stable(mem_wr_o) && $stable(mem_wdata_o));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> !req_ready_o);

  p_miss_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_o && !mem_rd_o && !mem_wr_o |=> mem_rd_o || mem_wr_o);

  p_evict_then_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_wr_o) |-> mem_rd_o);

  p_rsp_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_valid_i && req_ready_o && !req_we_i);

  p_err_late_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> $past(rsp_valid_o));
endmodule

bind wb_dcache wb_dcache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_we_i    (req_we_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/wb_dcache_bench.sv
`timescale 1ns/1ps
module wb_dcache_bench;
  localparam int MW = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        mem_rd, mem_wr, mem_ack;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0]  mem_wpar, mem_rpar;

  always #2 clk = ~clk;

  wb_dcache u_wb_dcache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wpar_o(mem_wpar), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .mem_rpar_i(mem_rpar)
  );

  logic [63:0] mem_d [MW];
  logic [7:0]  mem_p [MW];
  logic [63:0] ref_d [MW];
  logic [7:0]  bad_m [MW];

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0;
  int ack_gap = 0, gap_cnt = 0;
  logic        log_we [$];
  logic [31:0] log_addr [$];

  typedef struct { logic [63:0] d; logic e; } exp_t;
  exp_t exp_q [$];
  logic pend = 1'b0, pend_e = 1'b0;

  function automatic logic [7:0] par8(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  assign mem_rdata = mem_d[mem_addr[15:3]];
  assign mem_rpar  = mem_p[mem_addr[15:3]];

  // memory model with programmable acknowledge gap
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      gap_cnt <= 0;
    end else begin
      if (mem_ack && (mem_rd || mem_wr)) begin
        if (mem_wr) begin
          mem_d[mem_addr[15:3]] = mem_wdata;
          mem_p[mem_addr[15:3]] = mem_wpar;
          n_wr++;
        end else n_rd++;
        log_we.push_back(mem_wr);
        log_addr.push_back(mem_addr);
      end
      if (mem_ack) gap_cnt <= 0;
      else if (mem_rd || mem_wr) gap_cnt <= gap_cnt + 1;
      mem_ack <= (mem_rd || mem_wr) && !mem_ack && (gap_cnt >= ack_gap);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(rsp_err == pend_e, "R3 late parity flag", 64'(rsp_err), 64'(pend_e));
        pend = 1'b0;
      end else if (rsp_err) begin
        chk(1'b0, "R3 spurious late flag", 64'(rsp_err), 64'd0);
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", rsp_rdata, 64'd0);
        else begin
          exp_t it;
          it = exp_q.pop_front();
          chk(rsp_rdata == it.d, "R2 load data", rsp_rdata, it.d);
          pend   = 1'b1;
          pend_e = it.e;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [7:0] be,
                        input logic [63:0] wd, output int waits);
    int w;
    w = int'(a[15:3]);
    if (!we) begin
      exp_t it;
      it.d = ref_d[w];
      it.e = |(bad_m[w] & be);
      exp_q.push_back(it);
    end else begin
      for (int b = 0; b < 8; b++) if (be[b]) ref_d[w][8*b +: 8] = wd[8*b +: 8];
      bad_m[w] = bad_m[w] & ~be;
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    waits = 0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      waits++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  int  wt, rd0, wr0;

  task automatic mark();
    rd0 = n_rd; wr0 = n_wr;
    log_we.delete(); log_addr.delete();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < MW; i++) begin
      mem_d[i] = 64'(i) * 64'h9E37_79B9_7F4A_7C15 ^ 64'h0123_4567_89AB_CDEF;
      mem_p[i] = par8(mem_d[i]);
      ref_d[i] = mem_d[i];
      bad_m[i] = 8'h00;
    end
    do_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);
    chk(!mem_rd && !mem_wr, "R9 no beats after reset", 64'({mem_rd, mem_wr}), 64'd0);
    chk(!rsp_valid && !rsp_err, "R9 quiet outputs", 64'({rsp_valid, rsp_err}), 64'd0);

    // load miss on clean line
    mark();
    access(0, 32'h0100, 8'hFF, '0, wt);
    chk(wt >= 4, "R8 ready low during miss", 64'(wt), 64'd4);
    chk(n_rd - rd0 == 4 && n_wr == wr0, "R5 four reads no writes", 64'(n_rd - rd0), 64'd4);
    for (int k = 0; k < 4; k++)
      chk(log_addr[k] == 32'h0100 + 32'(8*k), "R5 beat order", 64'(log_addr[k]), 64'(32'h0100 + 32'(8*k)));

    // load hit, same cycle
    mark();
    access(0, 32'h0118, 8'hFF, '0, wt);
    chk(wt == 0 && n_rd == rd0, "R2 hit without stall or traffic", 64'(wt), 64'd0);

    // store hit merges
    mark();
    access(1, 32'h0108, 8'h0F, 64'h1122_3344_5566_7788, wt);
    chk(wt == 0 && n_rd == rd0 && n_wr == wr0, "R4 store hit local only", 64'(n_rd - rd0 + n_wr - wr0), 64'd0);
    access(0, 32'h0108, 8'hFF, '0, wt);

    // alias to dirty line: writeback then refill
    mark();
    access(0, 32'h4108, 8'hFF, '0, wt);
    chk(log_we.size() == 8, "R6 eight beats", 64'(log_we.size()), 64'd8);
    for (int k = 0; k < 8 && k < log_we.size(); k++) begin
      chk(log_we[k] == (k < 4), "R6 writes precede reads", 64'(log_we[k]), 64'(k < 4));
      chk(log_addr[k] == (k < 4 ? 32'h0100 : 32'h4100) + 32'(8*(k%4)), "R6 beat address",
          64'(log_addr[k]), 64'((k < 4 ? 32'h0100 : 32'h4100) + 32'(8*(k%4))));
    end
    chk(mem_d[32'h0108 >> 3] == ref_d[32'h0108 >> 3], "R6 victim data written back",
        mem_d[32'h0108 >> 3], ref_d[32'h0108 >> 3]);
    chk(mem_p[32'h0108 >> 3] == par8(ref_d[32'h0108 >> 3]), "R6 victim check bits",
        64'(mem_p[32'h0108 >> 3]), 64'(par8(ref_d[32'h0108 >> 3])));

    // evict clean alias, re-fetch stored data
    mark();
    access(0, 32'h0108, 8'hFF, '0, wt);
    chk(n_wr == wr0 && n_rd - rd0 == 4, "R5 clean eviction no writeback", 64'(n_wr - wr0), 64'd0);

    // top index aliasing
    mark();
    access(0, 32'h3FF8, 8'hFF, '0, wt);
    chk(log_addr.size() > 0 && log_addr[0] == 32'h3FE0, "R1 last line base", 64'(log_addr[0]), 64'h3FE0);
    mark();
    access(0, 32'h7FF8, 8'hFF, '0, wt);
    chk(n_rd - rd0 == 4, "R1 alias evicts last line", 64'(n_rd - rd0), 64'd4);
    mark();
    access(0, 32'h3FF8, 8'hFF, '0, wt);
    chk(n_rd - rd0 == 4, "R1 original misses again", 64'(n_rd - rd0), 64'd4);

    // store miss allocates, merges, dirty
    mark();
    access(1, 32'h0210, 8'hF0, 64'hDEAD_BEEF_0000_0000, wt);
    chk(n_rd - rd0 == 4 && n_wr == wr0, "R7 store miss refills", 64'(n_rd - rd0), 64'd4);
    access(0, 32'h0210, 8'hFF, '0, wt);
    mark();
    access(0, 32'h4210, 8'hFF, '0, wt);
    chk(n_wr - wr0 == 4, "R7 line left dirty", 64'(n_wr - wr0), 64'd4);
    chk(mem_d[32'h0210 >> 3] == ref_d[32'h0210 >> 3], "R7 merged bytes reach memory",
        mem_d[32'h0210 >> 3], ref_d[32'h0210 >> 3]);

    // parity fault injected in memory, detected late
    mem_p[32'h0300 >> 3] ^= 8'h04;
    bad_m[32'h0300 >> 3] = 8'h04;
    access(0, 32'h0300, 8'hFF, '0, wt);
    access(0, 32'h0300, 8'h03, '0, wt);
    access(1, 32'h0300, 8'h04, 64'h0000_0000_00AB_0000, wt);
    access(0, 32'h0300, 8'hFF, '0, wt);

    // slow memory acknowledge
    ack_gap = 3;
    mark();
    access(0, 32'h0500, 8'hFF, '0, wt);
    chk(n_rd - rd0 == 4 && log_addr.size() == 4, "R10 one transfer per beat", 64'(log_addr.size()), 64'd4);
    for (int k = 0; k < 4 && k < log_addr.size(); k++)
      chk(log_addr[k] == 32'h0500 + 32'(8*k), "R10 beat order under delay",
          64'(log_addr[k]), 64'(32'h0500 + 32'(8*k)));
    ack_gap = 0;

    // reset drops cached state, including a dirty line
    access(1, 32'h0400, 8'hFF, 64'h5555_AAAA_5555_AAAA, wt);
    @(negedge clk);
    do_reset();
    for (int i = 0; i < MW; i++) begin
      ref_d[i] = mem_d[i];
      bad_m[i] = par8(mem_d[i]) ^ mem_p[i];
    end
    mark();
    access(0, 32'h4400, 8'hFF, '0, wt);
    chk(n_wr == wr0 && n_rd - rd0 == 4, "R9 dirty bit cleared by reset", 64'(n_wr - wr0), 64'd0);
    mark();
    access(0, 32'h0118, 8'hFF, '0, wt);
    chk(n_rd - rd0 == 4, "R9 valid bit cleared by reset", 64'(n_rd - rd0), 64'd4);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every held load completed", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule